// File: doc/BRIEF.md
# Serial Receive Buffer and Status Flags

This block sits between the receive shifter of a serial port and the processor. When the shifter finishes a byte it raises a one-cycle completion pulse with the byte and an error indication. If the holding register is free, the block loads the byte into it and raises the data-ready flag. If the register still holds an unread byte, the new byte is dropped and the overrun flag is raised instead.

Both flags sit in a status byte. The processor clears a flag with a deliberate two-step sequence. First it reads the status while the flag is 1. Then it writes a 0 to that bit. A DMA read of the holding register also clears data-ready.

While overrun is set, reception is blocked. In clock-synchronous mode, transmission is also inhibited. A standby request clears both flags in the same way reset does.

Top module: `rx_buf_flags`

## Requirements
- R1: After reset, the status byte and the data register read 0, and tx_inhibit is 0.
- R2: A completion is accepted when rx_done=1, rx_err=0, rx_en=1, overrun=0 and standby=0. An accepted completion while data-ready (status bit 6) is 0 loads rx_byte into data_out and sets bit 6 on the next cycle.
- R3: An accepted completion while bit 6 is 1 sets overrun (status bit 5) and leaves data_out unchanged, unless the same cycle clears bit 6 (see R9).
- R4: A completion with rx_err=1, or with rx_en=0, changes neither data_out nor the status byte. Clearing rx_en keeps the data register and both flags.
- R5: Reading the status while a flag is 1 arms that flag. A status write clears a flag only when that flag is armed and the written bit is 0. Writing 1 never changes a flag. Every status write disarms both flags.
- R6: dma_rd clears bit 6 and disarms it. dma_rd leaves bit 5 alone.
- R7: While overrun is 1, rx_allow is 0 and completions are ignored. Otherwise rx_allow follows rx_en, and it is also 0 during standby.
- R8: tx_inhibit is 1 exactly when sync_mode=1 and overrun is 1.
- R9: If bit 6 is cleared in the same cycle as an accepted completion, the new byte is loaded, bit 6 stays 1 and no overrun is raised.
- R10: standby=1 clears both flags and both arm states on the next edge and keeps data_out.
- R11: Status bits other than 5 and 6 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby request; clears flags |
| rx_done | input | 1 | One-cycle reception-complete pulse |
| rx_err | input | 1 | The completing byte had a framing or parity error |
| rx_byte | input | DW | Received byte |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 = clock-synchronous, 0 = asynchronous |
| stat_rd | input | 1 | Processor reads the status byte |
| stat_wr | input | 1 | Processor writes the status byte |
| stat_wdata | input | SW | Status write data |
| dma_rd | input | 1 | DMA reads the data register |
| data_out | output | DW | Data register |
| stat_out | output | SW | Status byte |
| rx_allow | output | 1 | Shifter may accept a new byte |
| tx_inhibit | output | 1 | Transmission blocked |

## Verification
The bench builds the block with its default 8-bit data and status widths. At this size every byte value can be pushed through the load path. Every one of the 256 status write values can also be applied against both flags set and armed, and each result is checked against the written bits 5 and 6. Directed sequences then cover the cases that are specific to this block: overrun, blocked reception, error and disable pulses, a clear coinciding with a load, standby, and unarmed writes.

// File: rtl/rx_buf_flags.sv
module rx_buf_flags #(
  parameter int DW = 8,
  parameter int SW = 8,
  parameter int FULL_BIT = 6,
  parameter int OVR_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          rx_done,
  input  logic          rx_err,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_en,
  input  logic          sync_mode,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic [SW-1:0] stat_wdata,
  input  logic          dma_rd,
  output logic [DW-1:0] data_out,
  output logic [SW-1:0] stat_out,
  output logic          rx_allow,
  output logic          tx_inhibit
);
  logic full_q, ovr_q, arm_full_q, arm_ovr_q;
  logic [DW-1:0] data_q;

  wire full_clr = dma_rd | (stat_wr & ~stat_wdata[FULL_BIT] & arm_full_q);
  wire ovr_clr  = stat_wr & ~stat_wdata[OVR_BIT] & arm_ovr_q;
  wire take     = rx_done & ~rx_err & rx_allow;
  wire load     = take & (~full_q | full_clr);
  wire lost     = take & full_q & ~full_clr;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, stat_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      full_q     <= 1'b0;
      ovr_q      <= 1'b0;
      arm_full_q <= 1'b0;
      arm_ovr_q  <= 1'b0;
    end else if (standby) begin
      full_q     <= 1'b0;
      ovr_q      <= 1'b0;
      arm_full_q <= 1'b0;
      arm_ovr_q  <= 1'b0;
    end else begin
      if (load) data_q <= rx_byte;
      full_q     <= load | (full_q & ~full_clr);
      ovr_q      <= lost | (ovr_q & ~ovr_clr);
      arm_full_q <= (stat_wr | dma_rd) ? 1'b0 : (arm_full_q | (stat_rd & full_q));
      arm_ovr_q  <= stat_wr ? 1'b0 : (arm_ovr_q | (stat_rd & ovr_q));
    end
  end

  always_comb begin
    stat_out = '0;
    stat_out[FULL_BIT] = full_q;
    stat_out[OVR_BIT]  = ovr_q;
  end

  assign data_out   = data_q;
  assign rx_allow   = rx_en & ~ovr_q & ~standby;
  assign tx_inhibit = sync_mode & ovr_q;
endmodule

// File: rtl/rx_buf_flags_chk.sv
module rx_buf_flags_chk #(
  parameter int DW = 8,
  parameter int SW = 8,
  parameter int FULL_BIT = 6,
  parameter int OVR_BIT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic          rx_done,
  input logic          rx_err,
  input logic [DW-1:0] rx_byte,
  input logic          rx_en,
  input logic          sync_mode,
  input logic          stat_rd,
  input logic          stat_wr,
  input logic [SW-1:0] stat_wdata,
  input logic          dma_rd,
  input logic [DW-1:0] data_out,
  input logic [SW-1:0] stat_out,
  input logic          rx_allow,
  input logic          tx_inhibit
);
  wire full = stat_out[FULL_BIT];
  wire ovr  = stat_out[OVR_BIT];
  logic [SW-1:0] rsv_mask;
  always_comb begin
    rsv_mask = '1;
    rsv_mask[FULL_BIT] = 1'b0;
    rsv_mask[OVR_BIT]  = 1'b0;
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_err && rx_en && !standby && !ovr && !full) |=> (full && data_out == $past(rx_byte)));
  // R3
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_err && rx_en && !standby && !ovr && full && !dma_rd && !stat_wr) |=> (ovr && $stable(data_out)));
  // R4
  err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_err && !standby && !dma_rd && !stat_wr) |=> ($stable(stat_out) && $stable(data_out)));
  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(standby || stat_wr));
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(standby || stat_wr || dma_rd));
  // R7
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !rx_allow);
  // R8
  tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr |-> !tx_inhibit);
  // R10
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (stat_out == '0 && $stable(data_out)));
  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_out & rsv_mask) == '0);
endmodule

bind rx_buf_flags rx_buf_flags_chk #(.DW(DW), .SW(SW), .FULL_BIT(FULL_BIT), .OVR_BIT(OVR_BIT)) u_chk (.*);

// File: tb/test_rx_buf_flags.sv
module test_rx_buf_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0, standby = 1'b0, rx_done = 1'b0, rx_err = 1'b0;
  logic rx_en = 1'b1, sync_mode = 1'b0, stat_rd = 1'b0, stat_wr = 1'b0, dma_rd = 1'b0;
  logic [7:0] rx_byte = '0, stat_wdata = '0;
  logic [7:0] data_out, stat_out;
  logic rx_allow, tx_inhibit;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rx_buf_flags i_rx_buf_flags (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fin();
    @(negedge clk);
    rx_done = 0; rx_err = 0; stat_rd = 0; stat_wr = 0; dma_rd = 0; standby = 0;
  endtask
  task automatic rx(logic [7:0] b, logic e = 1'b0);
    @(negedge clk); rx_done = 1; rx_byte = b; rx_err = e; fin();
  endtask
  task automatic rd();
    @(negedge clk); stat_rd = 1; fin();
  endtask
  task automatic wr(logic [7:0] v);
    @(negedge clk); stat_wr = 1; stat_wdata = v; fin();
  endtask
  task automatic dma();
    @(negedge clk); dma_rd = 1; fin();
  endtask
  task automatic stby();
    @(negedge clk); standby = 1; fin();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", stat_out, 0);
    chk("R1 data", data_out, 0);
    chk("R1 tx_inhibit", tx_inhibit, 0);
    chk("R7 allow", rx_allow, 1);

    for (int b = 0; b < 256; b++) begin
      rx(8'(b));
      chk("R2 data", data_out, b);
      chk("R2 status", stat_out, 8'h40);
      if (b % 2 == 0) begin
        rd(); wr(8'hBF);
        chk("R5 read-write clear", stat_out, 0);
      end else begin
        dma();
        chk("R6 dma clear", stat_out, 0);
      end
    end

    rx(8'h5A); wr(8'h00);
    chk("R5 unarmed write", stat_out, 8'h40);
    rd(); wr(8'hFF);
    chk("R5 write one", stat_out, 8'h40);
    chk("R11 reserved", stat_out & 8'h9F, 0);
    wr(8'h00);
    chk("R5 disarmed by write", stat_out, 8'h40);
    rd(); wr(8'h00);
    chk("R5 clear", stat_out, 0);

    rx_en = 0; rx(8'hC3);
    chk("R4 rx_en off status", stat_out, 0);
    chk("R4 rx_en off data", data_out, 8'h5A);
    chk("R7 allow off", rx_allow, 0);
    rx_en = 1; rx(8'hC4, 1'b1);
    chk("R4 error status", stat_out, 0);
    chk("R4 error data", data_out, 8'h5A);
    rx(8'h11); rx_en = 0; @(negedge clk);
    chk("R4 disable keeps data", data_out, 8'h11);
    chk("R4 disable keeps flag", stat_out, 8'h40);
    rx_en = 1;

    rx(8'h22);
    chk("R3 overrun status", stat_out, 8'h60);
    chk("R3 overrun data", data_out, 8'h11);
    chk("R7 blocked", rx_allow, 0);
    chk("R8 async", tx_inhibit, 0);
    sync_mode = 1; @(negedge clk);
    chk("R8 sync", tx_inhibit, 1);
    rx(8'h33);
    chk("R7 ignored data", data_out, 8'h11);
    dma();
    chk("R6 dma keeps overrun", stat_out, 8'h20);
    rx(8'h44);
    chk("R7 ignored while overrun", stat_out, 8'h20);
    chk("R7 data kept", data_out, 8'h11);
    rd(); wr(8'h9F);
    chk("R5 overrun clear", stat_out, 0);
    chk("R8 released", tx_inhibit, 0);
    sync_mode = 0;

    rx(8'h55);
    @(negedge clk); dma_rd = 1; rx_done = 1; rx_byte = 8'h66; fin();
    chk("R9 dma+load status", stat_out, 8'h40);
    chk("R9 dma+load data", data_out, 8'h66);
    rd();
    @(negedge clk); stat_wr = 1; stat_wdata = 8'h00; rx_done = 1; rx_byte = 8'h77; fin();
    chk("R9 write+load status", stat_out, 8'h40);
    chk("R9 write+load data", data_out, 8'h77);

    rx(8'h88); rd(); stby();
    chk("R10 standby status", stat_out, 0);
    chk("R10 standby data", data_out, 8'h77);
    rx(8'h99); wr(8'h00);
    chk("R10 arms cleared", stat_out, 8'h40);

    for (int w = 0; w < 256; w++) begin
      stby();
      rx(8'hA0); rx(8'hA1); rd(); wr(8'(w));
      chk("R5 R11 write sweep", stat_out, w & 8'h60);
      chk("R3 sweep data", data_out, 8'hA0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule